// File: doc/BRIEF.md
# Memory Operand Address Generator

This unit turns the decoded parts of a memory operand into a linear address in one clock. Its inputs are a base value, an index value with a 2-bit scale code, a displacement that is either 8 or 32 bits wide, a bank of four 16-bit segment values with a selector, and the current addressing regime. The bank order is data, stack, extra, code. It runs in one of three regimes.

- **Real mode:** a segment value is shifted left by four and added to a 16-bit offset, and a gate input can fold the result back below 1 MB.
- **Flat 32-bit mode:** the scaled sum wraps at 2^32.
- **64-bit mode:** segment bases count as zero. An operand may be taken relative to the address of the next instruction. Every result is checked for canonical form, and a check failure produces a protection fault code or a stack fault code.

A pipeline places the unit between operand decode and the load/store queue. The pipeline presents one request per cycle with `req_valid`. One cycle later it reads the address and the fault code, qualified by `out_valid`. Descriptor lookups, limit checks and paging happen downstream.

Top module: `agu_top`

## Requirements
- R1: `out_valid` equals `req_valid` from one clock earlier. While reset is asserted, and in the first cycle after it, `out_valid`, `lin_addr` and `fault` are all zero.
- R2: The effective sum is base + (index << scale code). Scale codes 00, 01, 10 and 11 multiply the index by 1, 2, 4 and 8. A base or index whose enable is low contributes zero, whatever its value.
- R3: When `disp_short` is 1, `disp[7:0]` is sign-extended and added. When it is 0, `disp[31:0]` is sign-extended and added.
- R4: In mode 00 (real), the offset is the low 16 bits of the effective sum. `lin_addr` is the selected segment times 16 plus that offset, held in 21 bits with zero above. `fault` is 00, and `rip_rel` has no effect.
- R5: `seg_sel` value k picks `seg_bank[16k+15:16k]`. Slot 0 is data, 1 is stack, 2 is extra and 3 is code. The segment value is used only in real mode.
- R6: In real mode with `a20_en` = 0, bit 20 of `lin_addr` is zero. In the other modes `a20_en` has no effect.
- R7: In mode 01 (flat 32-bit), `lin_addr` is the effective sum modulo 2^32, zero-extended. `fault` is 00, and the segment values have no effect.
- R8: In mode 10 (64-bit), `lin_addr` is the full 64-bit effective sum, with no segment added. When `rip_rel` is 1, `lin_addr` is `next_ip` plus the sign-extended displacement, and base and index are ignored.
- R9: In mode 10, a result whose bits 63:47 are not all equal gives `fault` = 10 (stack fault) if `seg_sel` = 1, and 01 (protection fault) otherwise. The address is still output. A canonical result gives `fault` = 00.
- R10: Mode 11 is reserved and gives `fault` = 01 with `lin_addr` = 0.
- R11: Whenever `out_valid` is 0, `fault` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 2 | 00 real, 01 flat 32-bit, 10 64-bit, 11 reserved |
| base_val | input | 64 | Base register value |
| base_en | input | 1 | Base present |
| index_val | input | 64 | Index register value |
| index_en | input | 1 | Index present |
| scale_code | input | 2 | Index shift amount (x1, x2, x4, x8) |
| disp | input | 32 | Displacement; low byte only when short |
| disp_short | input | 1 | 1 = 8-bit displacement |
| rip_rel | input | 1 | Address relative to next instruction (64-bit mode) |
| next_ip | input | 64 | Address of the next instruction |
| seg_sel | input | 2 | Segment slot: 0 data, 1 stack, 2 extra, 3 code |
| seg_bank | input | 64 | Four 16-bit segment values, slot k at bits 16k+15:16k |
| a20_en | input | 1 | 1 lets bit 20 through in real mode |
| out_valid | output | 1 | Result valid |
| lin_addr | output | 64 | Linear address |
| fault | output | 2 | 00 none, 01 protection fault, 10 stack fault |

## Verification
The bound checker watches properties that must hold on every cycle:

- the one-cycle valid pipeline and the quiet fault code when idle;
- the 21-bit ceiling of real-mode results and their bit 20 when the gate is closed;
- the 32-bit ceiling in flat mode;
- the reserved-mode response;
- the agreement between the 64-bit fault code and the canonical form of the output address, including the stack-versus-protection choice.

Only the bench's vectors can show the actual sums, because the numbers themselves must be known. These cover:

- scale multiplication;
- sign extension of both displacement sizes;
- 16-bit offset wrap;
- segment slot selection;
- the next-instruction-relative form;
- operands that are marked absent but carry non-zero values.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    MODE_REAL   = 2'b00,
    MODE_FLAT32 = 2'b01,
    MODE_LONG   = 2'b10,
    MODE_RSVD   = 2'b11
  } agu_mode_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_GP    = 2'b01,
    FLT_STACK = 2'b10
  } agu_fault_e;

  localparam logic [1:0] SEG_SLOT_STACK = 2'd1;
endpackage

// File: rtl/agu_ea.sv
module agu_ea #(
  parameter int AW = 64,
  parameter int DW = 32
) (
  input  logic [AW-1:0] base_val,
  input  logic          base_en,
  input  logic [AW-1:0] index_val,
  input  logic          index_en,
  input  logic [1:0]    scale_code,
  input  logic [DW-1:0] disp,
  input  logic          disp_short,
  input  logic          rip_sel,
  input  logic [AW-1:0] next_ip,
  output logic [AW-1:0] ea
);
  localparam int SHORT_W = 8;

  function automatic logic [AW-1:0] widen_disp(input logic [DW-1:0] d, input logic short_d);
    if (short_d) return {{(AW-SHORT_W){d[SHORT_W-1]}}, d[SHORT_W-1:0]};
    return {{(AW-DW){d[DW-1]}}, d};
  endfunction

  function automatic logic [AW-1:0] scaled_index(input logic [AW-1:0] v, input logic [1:0] sc);
    return v << sc;
  endfunction

  logic [AW-1:0] base_term, index_term, disp_term;

  always_comb begin
    base_term  = base_en  ? base_val : '0;
    index_term = index_en ? scaled_index(index_val, scale_code) : '0;
    disp_term  = widen_disp(disp, disp_short);
    if (rip_sel) ea = next_ip + disp_term;
    else         ea = base_term + index_term + disp_term;
  end
endmodule

// File: rtl/agu_real.sv
module agu_real #(
  parameter int AW = 64,
  parameter int SW = 16
) (
  input  logic [4*SW-1:0] seg_bank,
  input  logic [1:0]      seg_sel,
  input  logic [AW-1:0]   ea,
  input  logic            a20_en,
  output logic [AW-1:0]   lin
);
  localparam int RW      = SW + 5;
  localparam int WRAP_B  = SW + 4;

  function automatic logic [RW-1:0] seg_compose(input logic [SW-1:0] s, input logic [SW-1:0] o);
    return {1'b0, s, 4'b0000} + {5'b00000, o};
  endfunction

  logic [SW-1:0] seg_val;
  logic [RW-1:0] real_sum;

  always_comb begin
    seg_val  = seg_bank[seg_sel*SW +: SW];
    real_sum = seg_compose(seg_val, ea[SW-1:0]);
    if (!a20_en) real_sum[WRAP_B] = 1'b0;
    lin = {{(AW-RW){1'b0}}, real_sum};
  end
endmodule

// File: rtl/agu_canon.sv
module agu_canon #(
  parameter int AW  = 64,
  parameter int VAB = 48
) (
  input  logic [AW-1:0] addr,
  output logic          canon_ok
);
  generate
    if (VAB < AW) begin : g_check
      logic [AW-VAB:0] top_bits;
      always_comb begin
        top_bits = addr[AW-1:VAB-1];
        canon_ok = (top_bits == '0) || (top_bits == '1);
      end
    end else begin : g_full
      assign canon_ok = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int AW  = 64,
  parameter int VAB = 48,
  parameter int DW  = 32,
  parameter int SW  = 16,
  parameter int FW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] base_val,
  input  logic          base_en,
  input  logic [AW-1:0] index_val,
  input  logic          index_en,
  input  logic [1:0]    scale_code,
  input  logic [DW-1:0] disp,
  input  logic          disp_short,
  input  logic          rip_rel,
  input  logic [AW-1:0] next_ip,
  input  logic [1:0]    seg_sel,
  input  logic [4*SW-1:0] seg_bank,
  input  logic          a20_en,
  output logic          out_valid,
  output logic [AW-1:0] lin_addr,
  output logic [1:0]    fault
);
  agu_mode_e     mode_e;
  logic          rip_sel;
  logic [AW-1:0] ea_raw;
  logic [AW-1:0] lin_real;
  logic          canon_ok;
  logic [AW-1:0] lin_next;
  agu_fault_e    fault_next;

  assign mode_e  = agu_mode_e'(mode);
  assign rip_sel = rip_rel && (mode_e == MODE_LONG);

  agu_ea #(.AW(AW), .DW(DW)) u_ea (
    .base_val(base_val), .base_en(base_en),
    .index_val(index_val), .index_en(index_en),
    .scale_code(scale_code), .disp(disp), .disp_short(disp_short),
    .rip_sel(rip_sel), .next_ip(next_ip), .ea(ea_raw)
  );

  agu_real #(.AW(AW), .SW(SW)) u_real (
    .seg_bank(seg_bank), .seg_sel(seg_sel), .ea(ea_raw),
    .a20_en(a20_en), .lin(lin_real)
  );

  agu_canon #(.AW(AW), .VAB(VAB)) u_canon (
    .addr(ea_raw), .canon_ok(canon_ok)
  );

  always_comb begin
    lin_next   = '0;
    fault_next = FLT_NONE;
    unique case (mode_e)
      MODE_REAL:   lin_next = lin_real;
      MODE_FLAT32: lin_next = {{(AW-FW){1'b0}}, ea_raw[FW-1:0]};
      MODE_LONG: begin
        lin_next = ea_raw;
        if (!canon_ok)
          fault_next = (seg_sel == SEG_SLOT_STACK) ? FLT_STACK : FLT_GP;
      end
      default: begin
        lin_next   = '0;
        fault_next = FLT_GP;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      lin_addr  <= '0;
      fault     <= FLT_NONE;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        lin_addr <= lin_next;
        fault    <= fault_next;
      end else begin
        fault    <= FLT_NONE;
      end
    end
  end
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int AW  = 64,
  parameter int VAB = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    mode,
  input logic [1:0]    seg_sel,
  input logic          a20_en,
  input logic          out_valid,
  input logic [AW-1:0] lin_addr,
  input logic [1:0]    fault
);
  logic out_canon;
  assign out_canon = (lin_addr[AW-1:VAB-1] == '0) || (lin_addr[AW-1:VAB-1] == '1);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  a_r4_real_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 2'b00) |=> (lin_addr[AW-1:21] == '0 && fault == 2'b00));
  a_r6_a20_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 2'b00 && !a20_en) |=> !lin_addr[20]);
  a_r7_flat_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 2'b01) |=> (lin_addr[AW-1:32] == '0 && fault == 2'b00));
  a_r9_fault_matches_form: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 2'b10) |=> ((fault == 2'b00) == out_canon));
  a_r9_stack_only_on_ss: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 2'b10 && seg_sel != 2'd1) |=> fault != 2'b10);
  a_r10_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 2'b11) |=> (fault == 2'b01 && lin_addr == '0));
  a_r11_quiet_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> fault == 2'b00);
endmodule

bind agu_top agu_checker #(.AW(AW), .VAB(VAB)) u_agu_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
  .seg_sel(seg_sel), .a20_en(a20_en), .out_valid(out_valid),
  .lin_addr(lin_addr), .fault(fault)
);

// File: tb/test_agu_top.sv
module test_agu_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  typedef struct packed {
    logic [1:0]  mode;
    logic [63:0] base;
    logic        ben;
    logic [63:0] idx;
    logic        ien;
    logic [1:0]  sc;
    logic [31:0] disp;
    logic        dsh;
    logic        rip;
    logic [63:0] nip;
    logic [1:0]  sel;
    logic [15:0] seg;
    logic        a20;
    logic [63:0] exp_lin;
    logic [1:0]  exp_flt;
  } vec_t;

  // mode, base, ben, idx, ien, sc, disp, dsh, rip, nip, sel, seg, a20, exp_lin, exp_flt
  localparam vec_t VECS [NV] = '{
    // R4 R5 real mode, slot 0, rip_rel ignored, 8-bit disp
    '{2'b00, 64'h10, 1'b1, 64'h0, 1'b0, 2'b00, 32'h05, 1'b1, 1'b1, 64'h9999, 2'd0, 16'h1234, 1'b1, 64'h12355, 2'b00},
    // R4 16-bit offset wrap
    '{2'b00, 64'hFFFF, 1'b1, 64'h0, 1'b0, 2'b00, 32'h02, 1'b1, 1'b0, 64'h0, 2'd0, 16'h0000, 1'b1, 64'h1, 2'b00},
    // R6 gate open: bit 20 kept
    '{2'b00, 64'h10, 1'b1, 64'h0, 1'b0, 2'b00, 32'h0, 1'b0, 1'b0, 64'h0, 2'd3, 16'hFFFF, 1'b1, 64'h100000, 2'b00},
    // R6 gate closed: wraps to zero
    '{2'b00, 64'h10, 1'b1, 64'h0, 1'b0, 2'b00, 32'h0, 1'b0, 1'b0, 64'h0, 2'd3, 16'hFFFF, 1'b0, 64'h0, 2'b00},
    // R2 R5 extra slot, scale x2, 32-bit disp
    '{2'b00, 64'h100, 1'b1, 64'h2, 1'b1, 2'b01, 32'h10, 1'b0, 1'b0, 64'h0, 2'd2, 16'h2000, 1'b1, 64'h20114, 2'b00},
    // R7 R2 flat wrap modulo 2^32, scale x8
    '{2'b01, 64'hFFFFFFF0, 1'b1, 64'h4, 1'b1, 2'b11, 32'h0, 1'b0, 1'b0, 64'h0, 2'd0, 16'h5000, 1'b1, 64'h10, 2'b00},
    // R3 R7 negative 8-bit disp
    '{2'b01, 64'h1000, 1'b1, 64'h0, 1'b0, 2'b00, 32'h000000FF, 1'b1, 1'b0, 64'h0, 2'd0, 16'h5000, 1'b1, 64'hFFF, 2'b00},
    // R8 R9 R6 long, top canonical, absent index ignored, a20 ignored
    '{2'b10, 64'h00007FFFFFFFFFF0, 1'b1, 64'h1234, 1'b0, 2'b00, 32'h0F, 1'b1, 1'b0, 64'h0, 2'd0, 16'h5000, 1'b0, 64'h00007FFFFFFFFFFF, 2'b00},
    // R9 non-canonical, data slot: protection fault
    '{2'b10, 64'h00007FFFFFFFFFF0, 1'b1, 64'h0, 1'b0, 2'b00, 32'h10, 1'b1, 1'b0, 64'h0, 2'd0, 16'h5000, 1'b1, 64'h0000800000000000, 2'b01},
    // R9 non-canonical, stack slot: stack fault
    '{2'b10, 64'h00007FFFFFFFFFF0, 1'b1, 64'h0, 1'b0, 2'b00, 32'h10, 1'b1, 1'b0, 64'h0, 2'd1, 16'h5000, 1'b1, 64'h0000800000000000, 2'b10},
    // R8 R3 next-instruction relative, negative 32-bit disp, base ignored
    '{2'b10, 64'h5555, 1'b1, 64'h0, 1'b0, 2'b00, 32'hFFFFFF00, 1'b0, 1'b1, 64'h1000, 2'd0, 16'h5000, 1'b1, 64'hF00, 2'b00},
    // R2 absent base ignored, scale x4
    '{2'b10, 64'h7777, 1'b0, 64'h3, 1'b1, 2'b10, 32'h0, 1'b0, 1'b0, 64'h0, 2'd0, 16'h5000, 1'b1, 64'hC, 2'b00},
    // R10 reserved mode
    '{2'b11, 64'h10, 1'b1, 64'h0, 1'b0, 2'b00, 32'h0, 1'b0, 1'b0, 64'h0, 2'd0, 16'h5000, 1'b1, 64'h0, 2'b01},
    // R9 below the high canonical boundary
    '{2'b10, 64'hFFFF800000000000, 1'b1, 64'h0, 1'b0, 2'b00, 32'hFF, 1'b1, 1'b0, 64'h0, 2'd0, 16'h5000, 1'b1, 64'hFFFF7FFFFFFFFFFF, 2'b01},
    // R9 at the high canonical boundary
    '{2'b10, 64'hFFFF800000000000, 1'b1, 64'h0, 1'b0, 2'b00, 32'h0, 1'b0, 1'b0, 64'h0, 2'd1, 16'h5000, 1'b1, 64'hFFFF800000000000, 2'b00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  mode = '0;
  logic [63:0] base_val = '0;
  logic        base_en = 1'b0;
  logic [63:0] index_val = '0;
  logic        index_en = 1'b0;
  logic [1:0]  scale_code = '0;
  logic [31:0] disp = '0;
  logic        disp_short = 1'b0;
  logic        rip_rel = 1'b0;
  logic [63:0] next_ip = '0;
  logic [1:0]  seg_sel = '0;
  logic [63:0] seg_bank = '0;
  logic        a20_en = 1'b1;
  logic        out_valid;
  logic [63:0] lin_addr;
  logic [1:0]  fault;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agu_top i_agu_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .base_val(base_val), .base_en(base_en), .index_val(index_val),
    .index_en(index_en), .scale_code(scale_code), .disp(disp),
    .disp_short(disp_short), .rip_rel(rip_rel), .next_ip(next_ip),
    .seg_sel(seg_sel), .seg_bank(seg_bank), .a20_en(a20_en),
    .out_valid(out_valid), .lin_addr(lin_addr), .fault(fault)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    mode = v.mode; base_val = v.base; base_en = v.ben;
    index_val = v.idx; index_en = v.ien; scale_code = v.sc;
    disp = v.disp; disp_short = v.dsh; rip_rel = v.rip; next_ip = v.nip;
    seg_sel = v.sel; a20_en = v.a20;
    seg_bank = {4{16'hABCD}};
    seg_bank[v.sel*16 +: 16] = v.seg;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset valid", {63'b0, out_valid}, 64'h0);
    check("R1 reset addr", lin_addr, 64'h0);
    check("R1 reset fault", {62'b0, fault}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {63'b0, out_valid}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      req_valid = 1'b1;
      @(negedge clk);
      check("R1 valid latency", {63'b0, out_valid}, 64'h1);
      check($sformatf("vector %0d address", i), lin_addr, VECS[i].exp_lin);
      check($sformatf("vector %0d fault", i), {62'b0, fault}, {62'b0, VECS[i].exp_flt});
    end

    // R11 idle after a faulting request: fault returns to none
    apply(VECS[8]);
    req_valid = 1'b1;
    @(negedge clk);
    check("R9 fault before idle", {62'b0, fault}, 64'h1);
    req_valid = 1'b0;
    @(negedge clk);
    check("R1 valid drops", {63'b0, out_valid}, 64'h0);
    check("R11 idle fault", {62'b0, fault}, 64'h0);

    // R5 stack slot in real mode yields no fault and uses slot 1
    apply('{2'b00, 64'h4, 1'b1, 64'h0, 1'b0, 2'b00, 32'h0, 1'b0, 1'b0, 64'h0, 2'd1, 16'h3000, 1'b1, 64'h30004, 2'b00});
    req_valid = 1'b1;
    @(negedge clk);
    check("R5 stack slot address", lin_addr, 64'h30004);
    check("R4 real no fault", {62'b0, fault}, 64'h0);

    // R1 reset mid-stream clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again valid", {63'b0, out_valid}, 64'h0);
    check("R1 reset again addr", lin_addr, 64'h0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule